// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the configuration registers that steer the card side of a host-to-card bus bridge. Each card socket owns one 16-bit control word: a card reset bit that comes out of reset asserted, enables for forwarding legacy display addresses and for filtering the legacy I/O range, and enables for reporting card-side system errors and parity errors. A master abort mode bit sits in the same word but is one flop shared by every socket. Next to the control words sits one 16-bit subsystem vendor identifier. Software can write it only while a lock input, driven by a system control register elsewhere, is low.

Access goes through a plain register port. The port has a byte offset, a socket select, a write strobe, write data and a combinational read word. The control word sits at offset 3Eh and the identifier at offset 40h. The bits do not all share one reset domain. The global reset restores every bit. The bus reset leaves the card reset bit alone, leaves the identifier alone, and leaves the error-report enables alone while power-management events are enabled. Every control bit is also driven out on a dedicated pin so that the rest of the bridge can use it directly.

Top module: `brc_regfile`

## Requirements
- R1: While the global reset is high at a clock edge, every control word returns to 0040h (card reset bit 6 = 1, all other bits 0), the master abort mode bit returns to 0, and the identifier returns to 0000h.
- R2: The bus reset does not change bit 6 (card reset) of any socket. Only the global reset returns bit 6 to 1.
- R3: Bits 1 (system error enable) and 0 (parity response enable) keep their value across a bus reset while the PME enable input is 1. They are cleared by a bus reset while the PME enable input is 0.
- R4: Bits 5 (master abort mode), 3 (display forward enable) and 2 (legacy I/O filter) are cleared by the bus reset, whatever the PME enable input is.
- R5: Bits 15 to 7 and bit 4 of the control word always read 0, and writing ones to them has no effect.
- R6: A control word write goes only to the socket named by the socket select. The exception is bit 5, which is one shared flop: a value written through any socket reads back the same through every socket.
- R7: Writes at offset 40h load the identifier when the lock input is 0 and are ignored when it is 1. The bus reset does not change the identifier.
- R8: Reads of any offset other than 3Eh and 40h return 0000h, and writes to such offsets change no register.
- R9: The global reset beats the bus reset and a write in the same cycle. The bus reset beats a write for the bits it clears, but a write in the same cycle still loads bit 6.
- R10: The outputs card_rst_o, vga_fwd_o, isa_filt_o, cserr_en_o and cperr_en_o follow bits 6, 3, 2, 1 and 0 of the matching socket's word. mabt_mode_o follows the shared bit 5. vid_o follows the identifier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| grst | input | 1 | Global reset, synchronous, active high |
| brst | input | 1 | Bus reset, synchronous, active high |
| pme_en | input | 1 | Power-management event enable; chooses how bits 1 and 0 react to the bus reset |
| vid_wlock | input | 1 | Identifier write lock, 1 = read-only |
| sock_sel | input | SEL_W | Socket targeted by control word access |
| addr | input | ADDR_W | Byte offset of the register accessed |
| we | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr and sock_sel |
| card_rst_o | output | NUM_SOCKETS | Card reset per socket |
| mabt_mode_o | output | 1 | Master abort reporting mode, shared |
| vga_fwd_o | output | NUM_SOCKETS | Display address forward enable per socket |
| isa_filt_o | output | NUM_SOCKETS | Legacy I/O range filter per socket |
| cserr_en_o | output | NUM_SOCKETS | Card system error forward enable per socket |
| cperr_en_o | output | NUM_SOCKETS | Card parity error response enable per socket |
| vid_o | output | 16 | Subsystem vendor identifier |

## Verification
The control word is written with all ones, with a single bit set, and through each socket in turn. These patterns separate the reserved bits from the implemented ones, show which bits are held per socket, and confirm that bit 5 is shared. The bus reset is applied once with PME enabled and once with it disabled. After each, reading back both sockets shows which reset domain every bit belongs to, with bit 6 left set in one socket and cleared in the other. Locked and unlocked identifier writes, accesses to unmapped offsets, and cycles in which resets and a write coincide separate the priority orderings from one another.

// File: rtl/brc_pkg.sv
package brc_pkg;

   localparam int REG_W = 16;

   localparam int B_CRST  = 6;
   localparam int B_MABT  = 5;
   localparam int B_VGA   = 3;
   localparam int B_ISA   = 2;
   localparam int B_SERR  = 1;
   localparam int B_PERR  = 0;

   localparam logic [REG_W-1:0] SOCK_BITS = 16'h004F;
   localparam logic [REG_W-1:0] CRST_DEF  = 16'h0040;

   typedef enum logic [1:0] {
      RD_GLOBAL_ONLY = 2'd0,
      RD_PME_CTX     = 2'd1,
      RD_ANY         = 2'd2
   } rdom_e;

   function automatic rdom_e domain_of(input int bitpos, input logic [REG_W-1:0] ctx_mask);
      if (bitpos == B_CRST)       return RD_GLOBAL_ONLY;
      else if (ctx_mask[bitpos])  return RD_PME_CTX;
      else                        return RD_ANY;
   endfunction

endpackage

// File: rtl/brc_ctrl_bit.sv
module brc_ctrl_bit
   import brc_pkg::*;
#(
   parameter rdom_e DOMAIN  = RD_ANY,
   parameter logic  RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic grst,
   input  logic brst,
   input  logic pme_en,
   input  logic wr,
   input  logic d,
   output logic q
);

   logic brst_hit;

   generate
      if (DOMAIN == RD_GLOBAL_ONLY) begin : g_glob
         assign brst_hit = 1'b0;
      end else if (DOMAIN == RD_PME_CTX) begin : g_ctx
         assign brst_hit = brst & ~pme_en;
      end else begin : g_any
         assign brst_hit = brst;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (grst)          q <= RST_VAL;
      else if (brst_hit) q <= RST_VAL;
      else if (wr)       q <= d;
   end

endmodule

// File: rtl/brc_sock_word.sv
module brc_sock_word
   import brc_pkg::*;
#(
   parameter logic [REG_W-1:0] CTX_MASK = 16'h0003
) (
   input  logic             clk,
   input  logic             grst,
   input  logic             brst,
   input  logic             pme_en,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] word
);

   generate
      for (genvar b = 0; b < REG_W; b++) begin : g_bit
         if (SOCK_BITS[b]) begin : g_impl
            brc_ctrl_bit #(
               .DOMAIN  (domain_of(b, CTX_MASK)),
               .RST_VAL (CRST_DEF[b])
            ) u_bit (
               .clk    (clk),
               .grst   (grst),
               .brst   (brst),
               .pme_en (pme_en),
               .wr     (wr),
               .d      (wdata[b]),
               .q      (word[b])
            );
         end else begin : g_rsvd
            assign word[b] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/brc_vid_reg.sv
module brc_vid_reg
   import brc_pkg::*;
#(
   parameter logic [REG_W-1:0] VID_DEF = '0
) (
   input  logic             clk,
   input  logic             grst,
   input  logic             wr,
   input  logic             lock,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] vid
);

   always_ff @(posedge clk) begin
      if (grst)              vid <= VID_DEF;
      else if (wr && !lock)  vid <= wdata;
   end

endmodule

// File: rtl/brc_rd_mux.sv
module brc_rd_mux
   import brc_pkg::*;
#(
   parameter int NUM_SOCKETS = 2,
   parameter int SEL_W       = 1
) (
   input  logic                   hit_bc,
   input  logic                   hit_vid,
   input  logic [SEL_W-1:0]       sock_sel,
   input  logic [REG_W-1:0]       words [NUM_SOCKETS],
   input  logic                   mabt,
   input  logic [REG_W-1:0]       vid,
   output logic [REG_W-1:0]       rdata
);

   logic [REG_W-1:0] sel_word;

   always_comb begin
      sel_word = '0;
      for (int s = 0; s < NUM_SOCKETS; s++) begin
         if (sock_sel == SEL_W'(s)) sel_word = words[s];
      end
      sel_word[B_MABT] = mabt;
   end

   always_comb begin
      if (hit_bc)       rdata = sel_word;
      else if (hit_vid) rdata = vid;
      else              rdata = '0;
   end

endmodule

// File: rtl/brc_regfile.sv
module brc_regfile
   import brc_pkg::*;
#(
   parameter int               NUM_SOCKETS = 2,
   parameter int               ADDR_W      = 8,
   parameter int               SEL_W       = (NUM_SOCKETS > 1) ? $clog2(NUM_SOCKETS) : 1,
   parameter logic [REG_W-1:0] CTX_MASK    = 16'h0003,
   parameter int               BC_OFFSET   = 'h3E,
   parameter int               VID_OFFSET  = 'h40
) (
   input  logic                   clk,
   input  logic                   grst,
   input  logic                   brst,
   input  logic                   pme_en,
   input  logic                   vid_wlock,
   input  logic [SEL_W-1:0]       sock_sel,
   input  logic [ADDR_W-1:0]      addr,
   input  logic                   we,
   input  logic [REG_W-1:0]       wdata,
   output logic [REG_W-1:0]       rdata,
   output logic [NUM_SOCKETS-1:0] card_rst_o,
   output logic                   mabt_mode_o,
   output logic [NUM_SOCKETS-1:0] vga_fwd_o,
   output logic [NUM_SOCKETS-1:0] isa_filt_o,
   output logic [NUM_SOCKETS-1:0] cserr_en_o,
   output logic [NUM_SOCKETS-1:0] cperr_en_o,
   output logic [REG_W-1:0]       vid_o
);

   localparam logic [REG_W-1:0] CTX_OK = SOCK_BITS & ~CRST_DEF;

   generate
      if (NUM_SOCKETS < 1) begin : g_bad_n
         $error("brc_regfile: NUM_SOCKETS must be at least 1");
      end
      if ((1 << SEL_W) < NUM_SOCKETS) begin : g_bad_sel
         $error("brc_regfile: SEL_W too narrow for NUM_SOCKETS");
      end
      if (ADDR_W < 7 || BC_OFFSET >= (1 << ADDR_W) || VID_OFFSET >= (1 << ADDR_W)) begin : g_bad_addr
         $error("brc_regfile: ADDR_W cannot hold the register offsets");
      end
      if (BC_OFFSET == VID_OFFSET) begin : g_bad_ofs
         $error("brc_regfile: register offsets must differ");
      end
      if ((CTX_MASK & ~CTX_OK) != '0) begin : g_bad_ctx
         $error("brc_regfile: CTX_MASK names bits outside the per-socket set");
      end
   endgenerate

   logic hit_bc;
   logic hit_vid;
   logic sel_ok;
   logic bc_wr;

   assign hit_bc  = (addr == ADDR_W'(BC_OFFSET));
   assign hit_vid = (addr == ADDR_W'(VID_OFFSET));
   assign sel_ok  = (32'(sock_sel) < NUM_SOCKETS);
   assign bc_wr   = we & hit_bc & sel_ok;

   logic [REG_W-1:0] words [NUM_SOCKETS];

   generate
      for (genvar s = 0; s < NUM_SOCKETS; s++) begin : g_sock
         logic sock_wr;
         assign sock_wr = bc_wr & (sock_sel == SEL_W'(s));

         brc_sock_word #(
            .CTX_MASK (CTX_MASK)
         ) u_word (
            .clk    (clk),
            .grst   (grst),
            .brst   (brst),
            .pme_en (pme_en),
            .wr     (sock_wr),
            .wdata  (wdata),
            .word   (words[s])
         );

         assign card_rst_o[s] = words[s][B_CRST];
         assign vga_fwd_o[s]  = words[s][B_VGA];
         assign isa_filt_o[s] = words[s][B_ISA];
         assign cserr_en_o[s] = words[s][B_SERR];
         assign cperr_en_o[s] = words[s][B_PERR];
      end
   endgenerate

   brc_ctrl_bit #(
      .DOMAIN  (domain_of(B_MABT, CTX_MASK)),
      .RST_VAL (1'b0)
   ) u_mabt (
      .clk    (clk),
      .grst   (grst),
      .brst   (brst),
      .pme_en (pme_en),
      .wr     (bc_wr),
      .d      (wdata[B_MABT]),
      .q      (mabt_mode_o)
   );

   brc_vid_reg #(
      .VID_DEF ('0)
   ) u_vid (
      .clk   (clk),
      .grst  (grst),
      .wr    (we & hit_vid),
      .lock  (vid_wlock),
      .wdata (wdata),
      .vid   (vid_o)
   );

   brc_rd_mux #(
      .NUM_SOCKETS (NUM_SOCKETS),
      .SEL_W       (SEL_W)
   ) u_rd (
      .hit_bc   (hit_bc & sel_ok),
      .hit_vid  (hit_vid),
      .sock_sel (sock_sel),
      .words    (words),
      .mabt     (mabt_mode_o),
      .vid      (vid_o),
      .rdata    (rdata)
   );

endmodule

// File: rtl/brc_regfile_chk.sv
module brc_regfile_chk #(
   parameter int NUM_SOCKETS = 2,
   parameter int ADDR_W      = 8,
   parameter int SEL_W       = 1,
   parameter int BC_OFFSET   = 'h3E,
   parameter int VID_OFFSET  = 'h40
) (
   input logic                   clk,
   input logic                   grst,
   input logic                   brst,
   input logic                   pme_en,
   input logic                   vid_wlock,
   input logic [SEL_W-1:0]       sock_sel,
   input logic [ADDR_W-1:0]      addr,
   input logic                   we,
   input logic [15:0]            rdata,
   input logic [NUM_SOCKETS-1:0] card_rst_o,
   input logic                   mabt_mode_o,
   input logic [NUM_SOCKETS-1:0] vga_fwd_o,
   input logic [NUM_SOCKETS-1:0] isa_filt_o,
   input logic [NUM_SOCKETS-1:0] cserr_en_o,
   input logic [NUM_SOCKETS-1:0] cperr_en_o,
   input logic [15:0]            vid_o
);

   logic bc_acc;
   logic vid_acc;
   assign bc_acc  = (addr == ADDR_W'(BC_OFFSET));
   assign vid_acc = (addr == ADDR_W'(VID_OFFSET));

   // R1 / R9: global reset wins over everything
   a_r1_grst_defaults: assert property (@(posedge clk)
      grst |=> (card_rst_o == '1) && !mabt_mode_o && (vga_fwd_o == '0) &&
               (isa_filt_o == '0) && (cserr_en_o == '0) && (cperr_en_o == '0) &&
               (vid_o == 16'h0000));

   // R2: card reset untouched by bus reset
   a_r2_crst_holds: assert property (@(posedge clk) disable iff (grst)
      (brst && !we) |=> $stable(card_rst_o));

   // R3: context bits survive bus reset while PME enabled
   a_r3_ctx_hold: assert property (@(posedge clk) disable iff (grst)
      (brst && pme_en && !we) |=> ($stable(cserr_en_o) && $stable(cperr_en_o)));

   // R3: context bits cleared by bus reset while PME disabled
   a_r3_ctx_clear: assert property (@(posedge clk) disable iff (grst)
      (brst && !pme_en) |=> ((cserr_en_o == '0) && (cperr_en_o == '0)));

   // R4: non-context bits always cleared by bus reset
   a_r4_nonctx_clear: assert property (@(posedge clk) disable iff (grst)
      brst |=> (!mabt_mode_o && (vga_fwd_o == '0) && (isa_filt_o == '0)));

   // R5: reserved positions read zero
   a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (grst)
      bc_acc |-> ((rdata[15:7] == 9'd0) && !rdata[4]));

   // R7: identifier holds when locked or not written, across bus reset
   a_r7_vid_locked: assert property (@(posedge clk) disable iff (grst)
      (!we || vid_wlock || !vid_acc) |=> $stable(vid_o));

   // R8: unmapped offsets read zero
   a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (grst)
      (!bc_acc && !vid_acc) |-> (rdata == 16'h0000));

endmodule

bind brc_regfile brc_regfile_chk #(
   .NUM_SOCKETS (NUM_SOCKETS),
   .ADDR_W      (ADDR_W),
   .SEL_W       (SEL_W),
   .BC_OFFSET   (BC_OFFSET),
   .VID_OFFSET  (VID_OFFSET)
) u_chk (
   .clk         (clk),
   .grst        (grst),
   .brst        (brst),
   .pme_en      (pme_en),
   .vid_wlock   (vid_wlock),
   .sock_sel    (sock_sel),
   .addr        (addr),
   .we          (we),
   .rdata       (rdata),
   .card_rst_o  (card_rst_o),
   .mabt_mode_o (mabt_mode_o),
   .vga_fwd_o   (vga_fwd_o),
   .isa_filt_o  (isa_filt_o),
   .cserr_en_o  (cserr_en_o),
   .cperr_en_o  (cperr_en_o),
   .vid_o       (vid_o)
);

// File: tb/brc_regfile_test.sv
module brc_regfile_test;

   localparam int CLK_PERIOD = 10;
   localparam int NS   = 2;
   localparam int AW   = 8;
   localparam int SW   = 1;
   localparam logic [AW-1:0] BC  = 8'h3E;
   localparam logic [AW-1:0] VID = 8'h40;

   logic          clk = 1'b0;
   logic          grst = 1'b1;
   logic          brst = 1'b0;
   logic          pme_en = 1'b0;
   logic          vid_wlock = 1'b0;
   logic [SW-1:0] sock_sel = '0;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic [15:0]   wdata = '0;
   logic [15:0]   rdata;
   logic [NS-1:0] card_rst_o, vga_fwd_o, isa_filt_o, cserr_en_o, cperr_en_o;
   logic          mabt_mode_o;
   logic [15:0]   vid_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   brc_regfile #(.NUM_SOCKETS(NS), .ADDR_W(AW)) uut (
      .clk(clk), .grst(grst), .brst(brst), .pme_en(pme_en), .vid_wlock(vid_wlock),
      .sock_sel(sock_sel), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
      .card_rst_o(card_rst_o), .mabt_mode_o(mabt_mode_o), .vga_fwd_o(vga_fwd_o),
      .isa_filt_o(isa_filt_o), .cserr_en_o(cserr_en_o), .cperr_en_o(cperr_en_o),
      .vid_o(vid_o)
   );

   // scoreboard
   logic [15:0] exp_q [$];
   string       tag_q [$];
   event        rd_ev;

   initial begin
      forever begin
         @(rd_ev);
         while (exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (rdata !== e) begin
               n_fail++;
               $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
         end
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", t, act, exp);
      end
   endtask

   task automatic rd(input int s, input logic [AW-1:0] a, input logic [15:0] e, input string t);
      @(negedge clk);
      sock_sel = SW'(s);
      addr     = a;
      #1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      ->rd_ev;
      #1;
   endtask

   task automatic wr(input int s, input logic [AW-1:0] a, input logic [15:0] d);
      @(negedge clk);
      sock_sel = SW'(s);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic cycle(input logic g, input logic b, input logic w,
                        input int s, input logic [AW-1:0] a, input logic [15:0] d);
      @(negedge clk);
      grst = g; brst = b; we = w;
      sock_sel = SW'(s); addr = a; wdata = d;
      @(negedge clk);
      grst = 1'b0; brst = 1'b0; we = 1'b0;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      grst = 1'b0;

      // R1 reset state
      rd(0, BC, 16'h0040, "R1 sock0 word");
      rd(1, BC, 16'h0040, "R1 sock1 word");
      rd(0, VID, 16'h0000, "R1 vid");
      chk(32'(card_rst_o), 32'h3, "R1 card_rst_o");
      chk(32'(mabt_mode_o), 32'h0, "R1 mabt");

      // R5 / R6 / R10: all ones into socket 0
      wr(0, BC, 16'hFFFF);
      rd(0, BC, 16'h006F, "R5 sock0 all ones");
      rd(1, BC, 16'h0060, "R6 sock1 sees shared bit5 only");
      chk(32'(cserr_en_o), 32'h1, "R10 cserr_en_o");
      chk(32'(cperr_en_o), 32'h1, "R10 cperr_en_o");
      chk(32'(vga_fwd_o),  32'h1, "R10 vga_fwd_o");
      chk(32'(isa_filt_o), 32'h1, "R10 isa_filt_o");
      chk(32'(mabt_mode_o), 32'h1, "R10 mabt_mode_o");

      // R6: single bit into socket 1, bit5 and bit6 written 0
      wr(1, BC, 16'h0002);
      rd(1, BC, 16'h0002, "R6 sock1 word");
      rd(0, BC, 16'h004F, "R6 sock0 sees shared bit5 cleared");
      chk(32'(card_rst_o), 32'h1, "R10 card_rst_o per socket");

      // R2/R3/R4: bus reset with PME enabled
      wr(0, BC, 16'h006F);
      pme_en = 1'b1;
      cycle(1'b0, 1'b1, 1'b0, 0, 8'h00, 16'h0000);
      rd(0, BC, 16'h0043, "R3 R4 sock0 after brst pme on");
      rd(1, BC, 16'h0002, "R2 R3 sock1 after brst pme on");

      // bus reset with PME disabled
      pme_en = 1'b0;
      cycle(1'b0, 1'b1, 1'b0, 0, 8'h00, 16'h0000);
      rd(0, BC, 16'h0040, "R3 sock0 after brst pme off");
      rd(1, BC, 16'h0000, "R2 sock1 card reset stays low");
      chk(32'(card_rst_o), 32'h1, "R2 card_rst_o after brst");

      // R7 identifier lock
      wr(0, VID, 16'h5A3C);
      rd(0, VID, 16'h5A3C, "R7 unlocked write");
      vid_wlock = 1'b1;
      wr(1, VID, 16'hBEEF);
      rd(0, VID, 16'h5A3C, "R7 locked write ignored");
      vid_wlock = 1'b0;
      cycle(1'b0, 1'b1, 1'b0, 0, 8'h00, 16'h0000);
      rd(0, VID, 16'h5A3C, "R7 vid kept over brst");
      chk(32'(vid_o), 32'h5A3C, "R10 vid_o");

      // R8 unmapped offsets
      wr(0, 8'h3C, 16'hFFFF);
      wr(1, 8'h42, 16'hFFFF);
      rd(0, 8'h3C, 16'h0000, "R8 read 3Ch");
      rd(0, 8'h42, 16'h0000, "R8 read 42h");
      rd(0, BC, 16'h0040, "R8 sock0 untouched");
      rd(1, BC, 16'h0000, "R8 sock1 untouched");
      rd(0, VID, 16'h5A3C, "R8 vid untouched");

      // R9: bus reset with write, pme off: bit6 loads, others cleared
      cycle(1'b0, 1'b1, 1'b1, 0, BC, 16'h002D);
      rd(0, BC, 16'h0000, "R9 brst beats write, bit6 written");
      chk(32'(card_rst_o), 32'h0, "R9 card_rst_o after brst+write");

      // R9: global with bus reset and write
      pme_en = 1'b1;
      wr(1, BC, 16'h0003);
      cycle(1'b1, 1'b1, 1'b1, 1, BC, 16'h0003);
      rd(1, BC, 16'h0040, "R9 grst wins sock1");
      rd(0, BC, 16'h0040, "R9 grst wins sock0");
      rd(0, VID, 16'h0000, "R1 R9 vid cleared by grst");
      chk(32'(card_rst_o), 32'h3, "R1 card_rst_o after grst");

      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=done");
      end
      #2;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule